// File: doc/BRIEF.md
# Rotating Triple-FIFO Hit Buffer

This block sits between a pixel matrix and a downstream merge network and buffers hit words per bunch crossing. It holds three small FIFOs, each five words deep. A bunch-crossing tick rotates their roles. At any time one FIFO takes words from the matrix, one drains its contents through a four-phase request/acknowledge port, and one is cleared. A FIFO therefore fills during one crossing, drains during the next, and is wiped during the one after that.

A snapshot port copies every slot of all three FIFOs into a shift chain. Each slot carries a valid bit. Writing and reading carry on while the snapshot is taken and while the chain shifts. The chain has a serial input and a serial output, so the chains of many columns can be linked into one long scan path.

Top module: `rot_fifo_buf`

## Requirements
- R1: After reset `rd_req_o`, `ovf_o` and `scan_out_o` are low. The first write period fills FIFO 0, and all FIFOs are empty.
- R2: Each cycle with `bx_tick_i` high moves the write target from FIFO 0 to 1, from 1 to 2 and from 2 back to 0. The words written in one period are offered on the read port during the next period.
- R3: A FIFO accepts at most 5 words in its write period, and further writes in that period are dropped. The first dropped write sets `ovf_o`, which stays high until reset.
- R4: When `rd_req_o` rises, `rd_data_o` is valid, and it stays stable while `rd_ack_i` is low. `rd_req_o` falls in the cycle after `rd_ack_i` is seen high. A new request is raised only after `rd_ack_i` has returned low.
- R5: Within a read period the words are delivered in the order they were written, and each word exactly once.
- R6: Words still unread when the read period ends are never delivered. After one cycle in the clear role the FIFO reads as empty in a snapshot. A transfer already raised before the tick completes.
- R7: A cycle with `scan_cap_i` high loads a 135-bit image. The image holds FIFO 0 slot 0 first, then slots 1 to 4, then FIFO 1 and then FIFO 2. Each slot is a valid bit followed by its 8 data bits, MSB first. A slot is valid when its index is below the FIFO's word count, and invalid slots carry zero data. After the load, `scan_out_o` shows the first bit of the image.
- R8: Each cycle with `scan_shift_i` high (and `scan_cap_i` low) advances the chain by one bit toward `scan_out_o` and enters `scan_in_i` at the tail. The bit entered on the n-th shift appears at `scan_out_o` after shift n+134.
- R9: Capture and shifting do not change the stored words or the words delivered on the read port.
- R10: When `scan_cap_i` and `scan_shift_i` are both high, the capture takes priority and no shift occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_tick_i | input | 1 | Bunch-crossing tick; rotates the FIFO roles |
| wr_valid_i | input | 1 | Matrix write strobe |
| wr_data_i | input | 8 | Matrix hit word |
| rd_req_o | output | 1 | Four-phase request toward the merge network |
| rd_data_o | output | 8 | Word offered with the request |
| rd_ack_i | input | 1 | Four-phase acknowledge |
| ovf_o | output | 1 | Sticky overflow flag |
| scan_cap_i | input | 1 | Load the snapshot image into the chain |
| scan_shift_i | input | 1 | Shift the chain by one bit |
| scan_in_i | input | 1 | Serial input from the previous chain |
| scan_out_o | output | 1 | Serial output toward the next chain |

## Verification
The handshake properties assume that the acknowledge follows the four-phase rules. The acknowledge rises only while a request is pending and falls only after the request has dropped. The bench's responder raises and lowers the acknowledge on falling edges, strictly in reply to the request level it samples, so it stays within these rules. The rotation properties assume any tick pattern is legal, including ticks on consecutive cycles. The bench uses back-to-back ticks on purpose to cut a read period to a single cycle.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int unsigned NUM_BUF = 3;
  typedef logic [1:0] sel_t;
  typedef enum logic [1:0] {HS_IDLE, HS_REQ, HS_DROP} hs_state_e;

  function automatic sel_t sel_next(sel_t s);
    return (s == sel_t'(NUM_BUF - 1)) ? sel_t'(0) : s + sel_t'(1);
  endfunction
endpackage

// File: rtl/rfb_store.sv
module rfb_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_en_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [CNT_W-1:0]              cnt_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  mem_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      mem_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (wr_en_i && cnt_o < DEPTH_C) begin
      mem_o[cnt_o] <= wr_data_i;
      cnt_o        <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rfb_rd_hs.sv
module rfb_rd_hs
  import rfb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [CNT_W-1:0]              rd_cnt_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]  rd_mem_i,
  output logic                          req_o,
  input  logic                          ack_i,
  output logic [DATA_W-1:0]             data_o
);
  hs_state_e        state_q;
  logic [CNT_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      ptr_q   <= '0;
      req_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      unique case (state_q)
        HS_IDLE: if (ptr_q < rd_cnt_i) begin
          data_o  <= rd_mem_i[ptr_q];
          req_o   <= 1'b1;
          ptr_q   <= ptr_q + CNT_W'(1);
          state_q <= HS_REQ;
        end
        HS_REQ: if (ack_i) begin
          req_o   <= 1'b0;
          state_q <= HS_DROP;
        end
        HS_DROP: if (!ack_i) state_q <= HS_IDLE;
        default: state_q <= HS_IDLE;
      endcase
      // new read period: restart at slot 0, a raised word still completes
      if (tick_i) ptr_q <= '0;
    end
  end
endmodule

// File: rtl/rfb_snap.sv
module rfb_snap
  import rfb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
  localparam int unsigned ENT_W   = DATA_W + 1,
  localparam int unsigned CHAIN_W = NUM_BUF * DEPTH * ENT_W
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       cap_i,
  input  logic                                       shift_i,
  input  logic                                       sin_i,
  input  logic [NUM_BUF-1:0][DEPTH-1:0][DATA_W-1:0]  mem_i,
  input  logic [NUM_BUF-1:0][CNT_W-1:0]              cnt_i,
  output logic                                       sout_o
);
  logic [CHAIN_W-1:0] img;
  logic [CHAIN_W-1:0] chain_q;

  always_comb begin
    img = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (CNT_W'(e) < cnt_i[b])
          img[CHAIN_W-1-(b*DEPTH+e)*ENT_W -: ENT_W] = {1'b1, mem_i[b][e]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chain_q <= '0;
    else if (cap_i)   chain_q <= img;
    else if (shift_i) chain_q <= {chain_q[CHAIN_W-2:0], sin_i};
  end

  assign sout_o = chain_q[CHAIN_W-1];
endmodule

// File: rtl/rot_fifo_buf.sv
module rot_fifo_buf
  import rfb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bx_tick_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_req_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rd_ack_i,
  output logic              ovf_o,
  input  logic              scan_cap_i,
  input  logic              scan_shift_i,
  input  logic              scan_in_i,
  output logic              scan_out_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  sel_t wr_sel, rd_sel, clr_sel;
  logic [NUM_BUF-1:0][DEPTH-1:0][DATA_W-1:0] mem;
  logic [NUM_BUF-1:0][CNT_W-1:0]             cnt;
  logic                                      wr_full;

  assign clr_sel = sel_next(wr_sel);
  assign rd_sel  = sel_next(clr_sel);
  assign wr_full = (cnt[wr_sel] >= DEPTH_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wr_sel <= '0;
    else if (bx_tick_i) wr_sel <= sel_next(wr_sel);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovf_o <= 1'b0;
    else if (wr_valid_i && wr_full)   ovf_o <= 1'b1;
  end

  for (genvar k = 0; k < NUM_BUF; k++) begin : g_buf
    rfb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_sel == sel_t'(k)),
      .wr_en_i   (wr_valid_i && wr_sel == sel_t'(k)),
      .wr_data_i (wr_data_i),
      .cnt_o     (cnt[k]),
      .mem_o     (mem[k])
    );
  end

  rfb_rd_hs #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (bx_tick_i),
    .rd_cnt_i (cnt[rd_sel]),
    .rd_mem_i (mem[rd_sel]),
    .req_o    (rd_req_o),
    .ack_i    (rd_ack_i),
    .data_o   (rd_data_o)
  );

  rfb_snap #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_snap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (scan_cap_i),
    .shift_i (scan_shift_i),
    .sin_i   (scan_in_i),
    .mem_i   (mem),
    .cnt_i   (cnt),
    .sout_o  (scan_out_o)
  );
endmodule

// File: rtl/rot_fifo_buf_chk.sv
module rot_fifo_buf_chk
  import rfb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          bx_tick_i,
  input logic                          rd_req_o,
  input logic                          rd_ack_i,
  input logic [DATA_W-1:0]             rd_data_o,
  input logic                          ovf_o,
  input sel_t                          wr_sel,
  input logic [NUM_BUF-1:0][CNT_W-1:0] cnt
);
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_data_o));
  // R4
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> !rd_req_o);
  // R4
  no_rereq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_o && rd_ack_i |=> !rd_req_o);
  // R3
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R2
  rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_tick_i |=> wr_sel == (($past(wr_sel) == 2'd2) ? 2'd0 : $past(wr_sel) + 2'd1));
  // R2
  hold_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bx_tick_i |=> $stable(wr_sel));
  for (genvar k = 0; k < NUM_BUF; k++) begin : g_cnt
    // R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt[k] <= CNT_W'(DEPTH));
  end
endmodule

bind rot_fifo_buf rot_fifo_buf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bx_tick_i (bx_tick_i),
  .rd_req_o  (rd_req_o),
  .rd_ack_i  (rd_ack_i),
  .rd_data_o (rd_data_o),
  .ovf_o     (ovf_o),
  .wr_sel    (wr_sel),
  .cnt       (cnt)
);

// File: tb/rot_fifo_buf_bench.sv
module rot_fifo_buf_bench;
  localparam int CLK_P   = 10;
  localparam int DATA_W  = 8;
  localparam int DEPTH   = 5;
  localparam int IMG_W   = 3 * DEPTH * (DATA_W + 1);
  localparam int NPER    = 6;
  localparam int NW [NPER] = '{3, 5, 0, 7, 1, 5};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bx = 1'b0, wr_v = 1'b0, ack = 1'b0;
  logic [DATA_W-1:0] wr_d = '0;
  logic cap = 1'b0, shift = 1'b0, sin = 1'b0;
  logic req, ovf, sout;
  logic [DATA_W-1:0] rd_d;

  int n_chk = 0, n_bad = 0;
  logic [DATA_W-1:0] rx [256];
  int rx_n = 0;
  logic [DATA_W-1:0] ex [256];
  int ex_n = 0;
  logic [IMG_W-1:0] img;

  always #(CLK_P/2) clk = ~clk;

  rot_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rot_fifo_buf (
    .clk_i(clk), .rst_ni(rst_n), .bx_tick_i(bx), .wr_valid_i(wr_v), .wr_data_i(wr_d),
    .rd_req_o(req), .rd_data_o(rd_d), .rd_ack_i(ack), .ovf_o(ovf),
    .scan_cap_i(cap), .scan_shift_i(shift), .scan_in_i(sin), .scan_out_o(sout));

  // four-phase responder
  initial forever begin
    @(negedge clk);
    if (req && !ack) begin
      if (rx_n < 256) rx[rx_n] = rd_d;
      rx_n++;
      ack = 1'b1;
    end else if (!req && ack) ack = 1'b0;
  end

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [DATA_W-1:0] d);
    wr_v = 1'b1; wr_d = d;
    @(negedge clk);
    wr_v = 1'b0;
  endtask

  task automatic tick();
    bx = 1'b1;
    @(negedge clk);
    bx = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    do_reset();
    // R1
    check("R1 req", int'(req), 0);
    check("R1 ovf", int'(ovf), 0);
    check("R1 scan_out", int'(sout), 0);

    // table: write NW[i] words, tick; previous period drains meanwhile (R2 R3 R5)
    for (int i = 0; i < NPER; i++) begin
      for (int j = 0; j < NW[i]; j++) begin
        wr(DATA_W'(i * 16 + j));
        if (j < DEPTH) begin ex[ex_n] = DATA_W'(i * 16 + j); ex_n++; end
      end
      // R3 overflow only once a period exceeded 5
      check("R3 ovf", int'(ovf), (i >= 3) ? 1 : 0);
      tick();
      idle(30);
      // R2: words of period i delivered during period i+1
      check("R2 delivered count", rx_n, ex_n);
    end
    // R5 order and uniqueness
    for (int k = 0; k < ex_n; k++) check("R5 word", int'(rx[k]), int'(ex[k]));

    // R6: read period cut to one cycle by back-to-back ticks
    do_reset();
    check("R1 ovf after reset", int'(ovf), 0);
    base = rx_n;
    wr(8'h11); wr(8'h22); wr(8'h33);
    bx = 1'b1;
    idle(2);
    bx = 1'b0;
    idle(10);
    check("R6 only raised word delivered", rx_n - base, 1);
    check("R6 raised word value", int'(rx[base]), 8'h11);
    cap = 1'b1; @(negedge clk); cap = 1'b0;
    check("R6 cleared slot invalid", int'(sout), 0);
    tick(); idle(15);
    check("R6 no late delivery", rx_n - base, 1);

    // R7..R10 snapshot
    do_reset();
    base = rx_n;
    wr(8'h3C); wr(8'h5B);
    img = '0;
    img[IMG_W-1 -: 9] = {1'b1, 8'h3C};
    img[IMG_W-10 -: 9] = {1'b1, 8'h5B};
    cap = 1'b1; shift = 1'b1; sin = 1'b0;
    @(negedge clk);
    cap = 1'b0;
    // R10: capture wins, first image bit shown
    check("R10 cap over shift", int'(sout), int'(img[IMG_W-1]));
    begin
      int bad = 0;
      for (int i = 1; i < IMG_W; i++) begin
        sin = ((i % 3) == 0);
        @(negedge clk);
        if (sout !== img[IMG_W-1-i]) bad++;
      end
      // R7 image layout
      check("R7 image bit mismatches", bad, 0);
      bad = 0;
      for (int i = IMG_W; i < IMG_W + 8; i++) begin
        sin = ((i % 3) == 0);
        @(negedge clk);
        if (sout !== (((i - IMG_W + 1) % 3) == 0)) bad++;
      end
      // R8 daisy pass-through
      check("R8 chained bit mismatches", bad, 0);
    end
    shift = 1'b0; sin = 1'b0;
    // R9: stored words unaffected by capture and shifting
    tick(); idle(20);
    check("R9 delivered count", rx_n - base, 2);
    check("R9 word0", int'(rx[base]), 8'h3C);
    check("R9 word1", int'(rx[base+1]), 8'h5B);
    // R8 shift idle keeps chain: no shift, output stable
    begin
      logic s0;
      s0 = sout;
      idle(3);
      check("R8 hold without shift", int'(sout), int'(s0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule